// File: doc/BRIEF.md
# GPIO Wake-Event Configuration Unit

This block keeps configuration for 64 general-purpose pins, split into two banks of 32. Software reaches every pin through two 32-bit registers. The select register names one pin. The access register reads or writes that pin's settings. Only the lower sixteen pins of each bank can raise wake events. On those pins the block synchronizes the input and can debounce it. It then checks for the chosen polarity, either as a level or as an edge. In edge mode it records a sticky status bit. All requests from pins that are enabled and have their input enabled are merged onto one wake output. The highest pin also feeds a synchronized power-button signal.

Register access uses a single write strobe and a one-bit address: 0 is the select register and 1 is the access register. Read data is combinational from the address. The debounce window is `DEB_TICKS` clock cycles. By default this is 16 ms at a 33 MHz block clock.

Top module: `gpio_wake_cfg`

## Requirements
- R1: After reset the select register reads 0. Every wake-capable pin reads 0x00000044 from the access register (debounce and input enable set). Every other pin reads 0x00000004.
- R2: Select bit 5 picks the bank (0: pins 0..31, 1: pins 32..63) and bits 4:0 pick the pin within the bank. The select register reads back bits 5:0 with all higher bits at 0. Writing the select register leaves every pin's stored configuration unchanged, and writing the access register leaves the select register unchanged.
- R3: Access register layout: bit 0 wake enable, bit 1 sticky edge status, bit 2 input enable, bit 4 edge mode (1) or level mode (0), bit 5 polarity (1 rising/high, 0 falling/low), bit 6 debounce enable. Bits 31:7 and bit 3 ignore writes and read 0. Written fields read back on the selected pin.
- R4: On pins 16..31 and 48..63, bits 0, 1, 4, 5 and 6 read 0 and ignore writes. These pins never affect the wake output. Bit 2 is still stored.
- R5: In level mode, an enabled pin requests wake while its filtered level equals the polarity bit.
- R6: In edge mode, a filtered transition to the polarity level sets the status bit. A transition to the other level does not. Status stays set until a 1 is written to bit 1 of the access register with that pin selected.
- R7: With debounce on, a new level is accepted only after it has stayed stable for `DEB_TICKS` cycles. A pulse shorter than that is discarded.
- R8: With debounce off, a pin change reaches the wake output after the third rising clock edge.
- R9: The wake output is the OR of the requests of all wake-capable pins whose wake enable and input enable bits are both 1. It is 0 when no pin is so armed.
- R10: `pwr_btn_o` equals the highest pin delayed by two clock cycles through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = select register, 1 = access register |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the addressed register |
| pin_i | input | 64 | Asynchronous pin inputs |
| wake_o | output | 1 | Combined wake request |
| pwr_btn_o | output | 1 | Synchronized copy of pin 63 |

## Verification
A wrong slot decode or a write that hits the wrong pin shows up on the next read of the access register. The bench sweeps all 64 pins, first through reset values and then through a distinct pattern per pin, and reads every pin back. A fault in the filter or the detector shows on `wake_o` within a fixed number of cycles of a pin change: three cycles with debounce off, and `DEB_TICKS` plus two cycles with debounce on. Sticky status faults show as a status bit that is missing or stuck when the access register is read back.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_STS  = 1;
  localparam int unsigned B_INEN = 2;
  localparam int unsigned B_EDGE = 4;
  localparam int unsigned B_POL  = 5;
  localparam int unsigned B_DEB  = 6;

  typedef struct packed {
    logic deb;
    logic pol;
    logic edge_md;
    logic en;
  } wcfg_t;

  localparam wcfg_t WCFG_RST = '{deb: 1'b1, pol: 1'b0, edge_md: 1'b0, en: 1'b0};
endpackage

// File: rtl/gpio_wake_regs.sv
module gpio_wake_regs
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned PINS_PER_BANK = 32,
  parameter int unsigned WAKE_PER_BANK = 16,
  localparam int unsigned NPINS = NUM_BANKS * PINS_PER_BANK,
  localparam int unsigned NW    = NUM_BANKS * WAKE_PER_BANK,
  localparam int unsigned SEL_W = $clog2(NPINS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [NW-1:0]        status_i,
  output logic [31:0]          rdata_o,
  output wcfg_t [NW-1:0]       wcfg_o,
  output logic [NPINS-1:0]     inen_o,
  output logic [NW-1:0]        sts_clr_o,
  output logic [SEL_W-1:0]     sel_o
);
  localparam int unsigned LOC_W  = $clog2(PINS_PER_BANK);
  localparam int unsigned BANK_W = SEL_W - LOC_W;
  localparam int unsigned NW_W   = $clog2(NW);

  logic [SEL_W-1:0]  sel_q;
  wcfg_t [NW-1:0]    wcfg_q;
  logic [NPINS-1:0]  inen_q;
  logic [BANK_W-1:0] sel_bank;
  logic [LOC_W-1:0]  sel_loc;
  logic              sel_cap;
  logic [NW_W-1:0]   sel_slot;
  logic              sel_wr, acc_wr;
  logic              unused_wd;

  assign unused_wd = ^wdata_i[31:7];
  assign sel_bank  = sel_q[SEL_W-1:LOC_W];
  assign sel_loc   = sel_q[LOC_W-1:0];
  assign sel_cap   = (32'(sel_loc) < WAKE_PER_BANK);
  assign sel_slot  = NW_W'(NW_W'(sel_bank) * NW_W'(WAKE_PER_BANK)) + NW_W'(sel_loc);
  assign sel_wr    = we_i && !addr_i;
  assign acc_wr    = we_i && addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (sel_wr) sel_q <= wdata_i[SEL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NW; w++) wcfg_q[w] <= WCFG_RST;
    end else if (acc_wr && sel_cap) begin
      for (int w = 0; w < NW; w++) begin
        if (sel_slot == NW_W'(w)) begin
          wcfg_q[w].en      <= wdata_i[B_EN];
          wcfg_q[w].edge_md <= wdata_i[B_EDGE];
          wcfg_q[w].pol     <= wdata_i[B_POL];
          wcfg_q[w].deb     <= wdata_i[B_DEB];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inen_q <= '1;
    else if (acc_wr) begin
      for (int p = 0; p < NPINS; p++)
        if (sel_q == SEL_W'(p)) inen_q[p] <= wdata_i[B_INEN];
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_clr
    assign sts_clr_o[w] = acc_wr && sel_cap && (sel_slot == NW_W'(w)) && wdata_i[B_STS];
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[SEL_W-1:0] = sel_q;
    end else begin
      rdata_o[B_INEN] = inen_q[sel_q];
      if (sel_cap) begin
        rdata_o[B_EN]   = wcfg_q[sel_slot].en;
        rdata_o[B_STS]  = status_i[sel_slot];
        rdata_o[B_EDGE] = wcfg_q[sel_slot].edge_md;
        rdata_o[B_POL]  = wcfg_q[sel_slot].pol;
        rdata_o[B_DEB]  = wcfg_q[sel_slot].deb;
      end
    end
  end

  assign wcfg_o = wcfg_q;
  assign inen_o = inen_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/gpio_wake_filter.sv
module gpio_wake_filter #(
  parameter int unsigned DEB_TICKS = 528000,
  localparam int unsigned CNT_W = $clog2(DEB_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic deb_en_i,
  output logic level_o
);
  logic [1:0]       sync_q;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else sync_q <= {sync_q[0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!deb_en_i) begin
      filt_q <= sync_q[1];
      cnt_q  <= '0;
    end else if (sync_q[1] == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(DEB_TICKS - 1)) begin
      filt_q <= sync_q[1];
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = filt_q;
endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic en_i,
  input  logic inen_i,
  input  logic pol_i,
  input  logic edge_md_i,
  input  logic clr_i,
  output logic status_o,
  output logic req_o
);
  logic lvl_q, sts_q, act, hit, armed;

  assign act   = (level_i == pol_i);
  assign hit   = (level_i != lvl_q) && act;
  assign armed = en_i && inen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      lvl_q <= level_i;
      if (armed && edge_md_i && hit) sts_q <= 1'b1;
      else if (clr_i) sts_q <= 1'b0;
    end
  end

  assign status_o = sts_q;
  assign req_o    = armed && (edge_md_i ? sts_q : act);
endmodule

// File: rtl/gpio_wake_cfg.sv
module gpio_wake_cfg
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned PINS_PER_BANK = 32,
  parameter int unsigned WAKE_PER_BANK = 16,
  parameter int unsigned CLK_KHZ       = 33000,
  parameter int unsigned DEB_MS        = 16,
  parameter int unsigned DEB_TICKS     = CLK_KHZ * DEB_MS
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               reg_we_i,
  input  logic                               reg_addr_i,
  input  logic [31:0]                        reg_wdata_i,
  output logic [31:0]                        reg_rdata_o,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_i,
  output logic                               wake_o,
  output logic                               pwr_btn_o
);
  localparam int unsigned NPINS = NUM_BANKS * PINS_PER_BANK;
  localparam int unsigned NW    = NUM_BANKS * WAKE_PER_BANK;
  localparam int unsigned SEL_W = $clog2(NPINS);

  wcfg_t [NW-1:0]   wcfg;
  logic [NPINS-1:0] inen;
  logic [NW-1:0]    sts, sts_clr, req, lvl, arm;
  logic [SEL_W-1:0] sel;
  logic [1:0]       pbtn_q;
  logic             unused_sig;

  assign unused_sig = ^{pin_i, inen};

  gpio_wake_regs #(
    .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK), .WAKE_PER_BANK(WAKE_PER_BANK)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .status_i(sts), .rdata_o(reg_rdata_o),
    .wcfg_o(wcfg), .inen_o(inen), .sts_clr_o(sts_clr), .sel_o(sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar p = 0; p < WAKE_PER_BANK; p++) begin : g_pin
      localparam int unsigned W = b * WAKE_PER_BANK + p;
      localparam int unsigned P = b * PINS_PER_BANK + p;

      gpio_wake_filter #(.DEB_TICKS(DEB_TICKS)) u_flt (
        .clk_i, .rst_ni,
        .pin_i(pin_i[P]), .deb_en_i(wcfg[W].deb), .level_o(lvl[W])
      );

      gpio_wake_detect u_det (
        .clk_i, .rst_ni,
        .level_i(lvl[W]), .en_i(wcfg[W].en), .inen_i(inen[P]),
        .pol_i(wcfg[W].pol), .edge_md_i(wcfg[W].edge_md),
        .clr_i(sts_clr[W]), .status_o(sts[W]), .req_o(req[W])
      );

      assign arm[W] = wcfg[W].en && inen[P];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pbtn_q <= '0;
    else pbtn_q <= {pbtn_q[0], pin_i[NPINS-1]};
  end

  assign pwr_btn_o = pbtn_q[1];
  assign wake_o    = |req;
endmodule

// File: rtl/gpio_wake_chk.sv
module gpio_wake_chk #(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned PINS_PER_BANK = 32,
  parameter int unsigned WAKE_PER_BANK = 16,
  localparam int unsigned NPINS = NUM_BANKS * PINS_PER_BANK,
  localparam int unsigned NW    = NUM_BANKS * WAKE_PER_BANK,
  localparam int unsigned SEL_W = $clog2(NPINS),
  localparam int unsigned LOC_W = $clog2(PINS_PER_BANK)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic [31:0]      reg_rdata_o,
  input logic [NPINS-1:0] pin_i,
  input logic             wake_o,
  input logic             pwr_btn_o,
  input logic [SEL_W-1:0] sel_i,
  input logic [NW-1:0]    arm_i
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_SEL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_addr_i |-> (reg_rdata_o[31:SEL_W] == '0) && (reg_rdata_o[SEL_W-1:0] == sel_i)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i) |=> $stable(sel_i)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i |-> (reg_rdata_o[31:7] == '0) && !reg_rdata_o[3]); // R3
  AST_NONCAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i && (32'(sel_i[LOC_W-1:0]) >= WAKE_PER_BANK)) |-> ((reg_rdata_o & 32'h73) == '0)); // R4
  AST_IDLE_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i == '0) |-> !wake_o); // R9
  AST_PWR_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (pwr_btn_o == $past(pin_i[NPINS-1], 2))); // R10
endmodule

bind gpio_wake_cfg gpio_wake_chk #(
  .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK), .WAKE_PER_BANK(WAKE_PER_BANK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .pin_i(pin_i), .wake_o(wake_o), .pwr_btn_o(pwr_btn_o),
  .sel_i(sel), .arm_i(arm)
);

// File: tb/gpio_wake_cfg_tb_top.sv
`timescale 1ns/1ps
module gpio_wake_cfg_tb_top;
  localparam int unsigned DEB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] pins = '0;
  logic        wake, pbtn;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_wake_cfg #(.DEB_TICKS(DEB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pins),
    .wake_o(wake), .pwr_btn_o(pbtn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cyc(2); rst_n = 1'b1;
  endtask

  function automatic bit cap(input int i);
    return (i % 32) < 16;
  endfunction

  initial begin
    logic [31:0] v, e;
    cyc(3); rst_n = 1'b1;

    rd(0, v); chk(v == 0, "R1 select reset", v, 0);
    rd(1, v); chk(v == 32'h44, "R1 access reset pin0", v, 32'h44);
    chk(wake == 1'b0, "R1 wake reset", {31'b0, wake}, 0);
    chk(pbtn == 1'b0, "R10 pwr reset", {31'b0, pbtn}, 0);

    for (int i = 0; i < 64; i++) begin
      wr(0, 32'hFFFF_FFC0 | i);
      rd(0, v); chk(v == i, "R2 select readback", v, i);
      e = cap(i) ? 32'h44 : 32'h04;
      rd(1, v); chk(v == e, "R1 per-pin reset value", v, e);
    end

    for (int i = 0; i < 64; i++) begin
      wr(0, i);
      wr(1, 32'hFFFF_FF80 | ((i * 23 + 5) & 32'h7D));
    end
    for (int i = 0; i < 64; i++) begin
      wr(0, i);
      e = ((i * 23 + 5) & 32'h7D) & (cap(i) ? 32'h75 : 32'h04);
      rd(1, v); chk(v == e, "R3 R4 pattern readback", v, e);
    end
    do_reset();

    // level mode, debounce off, pin 3
    wr(0, 3); wr(1, 32'h25);
    chk(wake == 1'b0, "R5 level inactive", {31'b0, wake}, 0);
    @(negedge clk); pins[3] = 1'b1;
    cyc(1); chk(wake == 1'b0, "R8 not before third edge", {31'b0, wake}, 0);
    cyc(2); chk(wake == 1'b1, "R8 level after third edge", {31'b0, wake}, 1);
    wr(1, 32'h05);
    chk(wake == 1'b0, "R5 polarity low, pin high", {31'b0, wake}, 0);
    @(negedge clk); pins[3] = 1'b0;
    cyc(4); chk(wake == 1'b1, "R5 active low level", {31'b0, wake}, 1);
    rd(1, v); chk(v == 32'h05, "R6 no status in level mode", v, 32'h05);
    wr(1, 32'h04); chk(wake == 1'b0, "R9 enable off", {31'b0, wake}, 0);
    wr(1, 32'h01); chk(wake == 1'b0, "R9 input enable off", {31'b0, wake}, 0);

    // edge mode, pin 40 (bank 1)
    wr(0, 40); wr(1, 32'h35);
    @(negedge clk); pins[40] = 1'b1;
    cyc(5); rd(1, v); chk(v == 32'h37, "R6 rising edge sets status", v, 32'h37);
    chk(wake == 1'b1, "R6 wake from status", {31'b0, wake}, 1);
    @(negedge clk); pins[40] = 1'b0;
    cyc(5); rd(1, v); chk(v == 32'h37, "R6 status sticky", v, 32'h37);
    wr(1, 32'h37); rd(1, v); chk(v == 32'h35, "R6 write one clears", v, 32'h35);
    chk(wake == 1'b0, "R6 wake after clear", {31'b0, wake}, 0);
    wr(1, 32'h15);
    @(negedge clk); pins[40] = 1'b1;
    cyc(5); rd(1, v); chk(v == 32'h15, "R6 wrong edge ignored", v, 32'h15);
    @(negedge clk); pins[40] = 1'b0;
    cyc(5); rd(1, v); chk(v == 32'h17, "R6 falling edge sets status", v, 32'h17);
    wr(1, 32'h06); rd(1, v); chk(v == 32'h04, "R6 clear and disarm", v, 32'h04);
    chk(wake == 1'b0, "R9 nothing armed", {31'b0, wake}, 0);

    // debounce, pin 3
    wr(0, 3); wr(1, 32'h65);
    @(negedge clk); pins[3] = 1'b1;
    cyc(4); pins[3] = 1'b0;
    cyc(20); chk(wake == 1'b0, "R7 short pulse rejected", {31'b0, wake}, 0);
    pins[3] = 1'b1;
    cyc(DEB); chk(wake == 1'b0, "R7 not yet accepted", {31'b0, wake}, 0);
    cyc(4); chk(wake == 1'b1, "R7 accepted after window", {31'b0, wake}, 1);
    wr(1, 32'h04);

    // non-capable pin 20
    wr(0, 20); wr(1, 32'h77);
    rd(1, v); chk(v == 32'h04, "R4 non-capable bits ignored", v, 32'h04);
    @(negedge clk); pins[20] = 1'b1;
    cyc(5); chk(wake == 1'b0, "R4 no wake from non-capable", {31'b0, wake}, 0);
    wr(0, 3); rd(1, v); chk(v == 32'h04, "R2 other pin untouched", v, 32'h04);

    // power button
    @(negedge clk); pins[63] = 1'b1;
    cyc(1); chk(pbtn == 1'b0, "R10 one edge", {31'b0, pbtn}, 0);
    cyc(1); chk(pbtn == 1'b1, "R10 two edges", {31'b0, pbtn}, 1);
    @(negedge clk); pins[63] = 1'b0;
    cyc(2); chk(pbtn == 1'b0, "R10 release", {31'b0, pbtn}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule